// File: doc/BRIEF.md
# Low-Power Mode Pin State Controller

This block sits beside a small microcontroller core and owns its two low-power modes, idle and power-down. Software enters a mode by writing a two-bit power-control value. The block then gates the core clock, and in power-down also the oscillator. It overrides the external bus strobes, the four 8-bit ports and the PWM outputs. The override chosen depends on the mode and on whether code is being fetched from internal or external program memory.

Idle is left by an enabled interrupt request. Power-down is left only by the hardware reset pin. After that pin deasserts, the internal reset stays asserted until an oscillator-stable indication has been seen high for a programmable number of consecutive clock cycles. The mode bits clear themselves on exit, so the control value read back always shows the current mode.

Top module: `lpm_pin_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o` is 1, the mode is normal, `pcon_o` is 00, and `cpu_clk_en_o` and `osc_en_o` are 1.
- R2: After `rst_ni` rises, `sys_rst_o` falls only after `osc_stable_i` has been sampled high on `STABLE_CYC` consecutive rising edges. A low sample restarts the count.
- R3: Once released, `sys_rst_o` stays low until `rst_ni` goes low again, whatever `osc_stable_i` does.
- R4: A write in normal mode with bit 1 set enters power-down on the next edge, and `pcon_o` becomes 10. This holds even when bit 0 is also set. A write with only bit 0 set enters idle, and `pcon_o` becomes 01. Writes of 00 and writes in a low-power mode are ignored.
- R5: Idle returns to normal on the edge after `irq_i` is seen high, with `pcon_o` back to 00. `irq_i` has no effect in normal or power-down mode.
- R6: Power-down is left only by `rst_ni` going low. That clears the mode at once.
- R7: `cpu_clk_en_o` is 1 only in normal mode. `osc_en_o` is 0 only in power-down.
- R8: In normal mode, `ale_o`, `psen_o`, `port_o`, `port_oe_o` and `pwm_o` follow the normal inputs, and `pwm_oe_o` is all ones.
- R9: In idle, `ale_o` and `psen_o` are 1. In power-down, both are 0.
- R10: In either low-power mode, port 0 has its output enable at 0 and drives 0 when `ext_prog_i`=1. It drives its latch with output enable 1 when `ext_prog_i`=0.
- R11: In idle with `ext_prog_i`=1, port 2 drives its normal (address) value. In every other low-power case, port 2 drives its latch.
- R12: In both low-power modes, ports 1 and 3 drive their latches with output enable 1, so every latched 1 is held high. The PWM outputs have output enable 0 and value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hardware reset pin, active low, asynchronous |
| osc_stable_i | input | 1 | Oscillator-stable indication |
| pcon_we_i | input | 1 | Power-control write strobe |
| pcon_wdata_i | input | 2 | Write data: bit 0 idle, bit 1 power-down |
| irq_i | input | 1 | Any enabled interrupt request |
| ext_prog_i | input | 1 | 1 = code fetched from external program memory |
| ale_i | input | 1 | Normal-mode address latch strobe |
| psen_i | input | 1 | Normal-mode program store strobe |
| port_drv_i | input | 4x8 | Normal-mode port drive values (address/data included) |
| port_lat_i | input | 4x8 | Port latch contents |
| port_oe_i | input | 4 | Normal-mode per-port output enables |
| pwm_i | input | PWM_N | Normal-mode PWM values |
| sys_rst_o | output | 1 | Internal reset, active high |
| cpu_clk_en_o | output | 1 | Core clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| pcon_o | output | 2 | Current mode bits: bit 0 idle, bit 1 power-down |
| ale_o | output | 1 | Final ALE pin value |
| psen_o | output | 1 | Final PSEN pin value |
| port_o | output | 4x8 | Final port pin values |
| port_oe_o | output | 4 | Per-port output enables |
| pwm_o | output | PWM_N | Final PWM values |
| pwm_oe_o | output | PWM_N | PWM output enables |

## Verification
The assertions check on every cycle the mode transitions that follow from one edge. These are power-down priority on a write, idle exit on an interrupt, and power-down holding without reset. They also check that the reset stays held while the oscillator is not stable and stays released once dropped, that the mode bits are never both set, and the strobe and port overrides for each mode. The bench scenarios cover what needs a longer history. That is the exact cycle of reset release after a counted run of stable samples, the restart of that count after a glitch, and the asynchronous exit from power-down through the reset pin. They also cover stimuli that must have no effect: interrupts in normal and power-down, and writes while in a low-power mode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int NPORT  = 4;
  localparam int PORT_W = 8;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_PD   = 2'b10
  } lpm_mode_e;

  localparam int BIT_IDLE = 0;
  localparam int BIT_PD   = 1;
endpackage

// File: rtl/lpm_rst_release.sv
module lpm_rst_release #(
  parameter int STABLE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_stable_i,
  output logic sys_rst_o
);
  localparam int CNT_W = $clog2(STABLE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sys_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sys_rst_q <= 1'b1;
    end else if (sys_rst_q) begin
      if (!osc_stable_i) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(STABLE_CYC - 1)) begin
        sys_rst_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sys_rst_o = sys_rst_q;

  // R2: no release while the oscillator is not stable
  a_r2_hold_unstable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_q && !osc_stable_i) |=> sys_rst_q);
  // R3: release is sticky until the pin reset
  a_r3_sticky_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_q |=> !sys_rst_q);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sys_rst_i,
  input  logic      pcon_we_i,
  input  logic [1:0] pcon_wdata_i,
  input  logic      irq_i,
  output lpm_mode_e mode_o
);
  lpm_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (pcon_we_i) begin
          if (pcon_wdata_i[BIT_PD])        mode_d = MODE_PD;   // power-down wins
          else if (pcon_wdata_i[BIT_IDLE]) mode_d = MODE_IDLE;
        end
      end
      MODE_IDLE: if (irq_i) mode_d = MODE_RUN;
      MODE_PD:   mode_d = MODE_PD;                            // only the pin reset exits
      default:   mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_RUN;
    else if (sys_rst_i) mode_q <= MODE_RUN;
    else                mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R4
  a_r4_pd_priority: assert property (@(posedge clk_i) disable iff (!rst_ni || sys_rst_i)
    (mode_q == MODE_RUN && pcon_we_i && pcon_wdata_i[BIT_PD]) |=> (mode_q == MODE_PD));
  // R5
  a_r5_idle_wake: assert property (@(posedge clk_i) disable iff (!rst_ni || sys_rst_i)
    (mode_q == MODE_IDLE && irq_i) |=> (mode_q == MODE_RUN));
  // R6
  a_r6_pd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PD) |=> (mode_q == MODE_PD));
  // R4: mode bits never both set
  a_r4_onehot_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mode_q));
endmodule

// File: rtl/lpm_pin_mux.sv
module lpm_pin_mux
  import lpm_pkg::*;
#(
  parameter int PWM_N = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  lpm_mode_e                    mode_i,
  input  logic                         ext_prog_i,
  input  logic                         ale_i,
  input  logic                         psen_i,
  input  logic [NPORT-1:0][PORT_W-1:0] port_drv_i,
  input  logic [NPORT-1:0][PORT_W-1:0] port_lat_i,
  input  logic [NPORT-1:0]             port_oe_i,
  input  logic [PWM_N-1:0]             pwm_i,
  output logic                         ale_o,
  output logic                         psen_o,
  output logic [NPORT-1:0][PORT_W-1:0] port_o,
  output logic [NPORT-1:0]             port_oe_o,
  output logic [PWM_N-1:0]             pwm_o,
  output logic [PWM_N-1:0]             pwm_oe_o
);
  logic run, idle, pd;
  assign run  = (mode_i == MODE_RUN);
  assign idle = (mode_i == MODE_IDLE);
  assign pd   = (mode_i == MODE_PD);

  always_comb begin
    if (run) begin
      ale_o  = ale_i;
      psen_o = psen_i;
    end else begin
      ale_o  = idle;
      psen_o = idle;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_comb begin
      if (run) begin
        port_o[p]    = port_drv_i[p];
        port_oe_o[p] = port_oe_i[p];
      end else if (p == 0 && ext_prog_i) begin
        port_o[p]    = '0;                 // bus released
        port_oe_o[p] = 1'b0;
      end else if (p == 2 && ext_prog_i && idle) begin
        port_o[p]    = port_drv_i[p];      // address byte keeps flowing
        port_oe_o[p] = 1'b1;
      end else begin
        port_o[p]    = port_lat_i[p];
        port_oe_o[p] = 1'b1;
      end
    end
  end

  for (genvar w = 0; w < PWM_N; w++) begin : g_pwm
    assign pwm_o[w]    = run ? pwm_i[w] : 1'b0;
    assign pwm_oe_o[w] = run;
  end

  // R9
  a_r9_pd_strobes_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd |-> (!ale_o && !psen_o));
  // R10
  a_r10_p0_float_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && ext_prog_i) |-> !port_oe_o[0]);
  // R12
  a_r12_pwm_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (pwm_oe_o == '0));
  // R11
  a_r11_p2_pd_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd |-> (port_o[2] == port_lat_i[2] && port_oe_o[2]));
endmodule

// File: rtl/lpm_pin_ctrl.sv
module lpm_pin_ctrl
  import lpm_pkg::*;
#(
  parameter int STABLE_CYC = 16,
  parameter int PWM_N      = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         osc_stable_i,
  input  logic                         pcon_we_i,
  input  logic [1:0]                   pcon_wdata_i,
  input  logic                         irq_i,
  input  logic                         ext_prog_i,
  input  logic                         ale_i,
  input  logic                         psen_i,
  input  logic [NPORT-1:0][PORT_W-1:0] port_drv_i,
  input  logic [NPORT-1:0][PORT_W-1:0] port_lat_i,
  input  logic [NPORT-1:0]             port_oe_i,
  input  logic [PWM_N-1:0]             pwm_i,
  output logic                         sys_rst_o,
  output logic                         cpu_clk_en_o,
  output logic                         osc_en_o,
  output logic [1:0]                   pcon_o,
  output logic                         ale_o,
  output logic                         psen_o,
  output logic [NPORT-1:0][PORT_W-1:0] port_o,
  output logic [NPORT-1:0]             port_oe_o,
  output logic [PWM_N-1:0]             pwm_o,
  output logic [PWM_N-1:0]             pwm_oe_o
);
  lpm_mode_e mode;
  logic      sys_rst;

  lpm_rst_release #(.STABLE_CYC(STABLE_CYC)) u_rst (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .osc_stable_i (osc_stable_i),
    .sys_rst_o    (sys_rst)
  );

  lpm_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sys_rst_i    (sys_rst),
    .pcon_we_i    (pcon_we_i),
    .pcon_wdata_i (pcon_wdata_i),
    .irq_i        (irq_i),
    .mode_o       (mode)
  );

  lpm_pin_mux #(.PWM_N(PWM_N)) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .ext_prog_i (ext_prog_i),
    .ale_i      (ale_i),
    .psen_i     (psen_i),
    .port_drv_i (port_drv_i),
    .port_lat_i (port_lat_i),
    .port_oe_i  (port_oe_i),
    .pwm_i      (pwm_i),
    .ale_o      (ale_o),
    .psen_o     (psen_o),
    .port_o     (port_o),
    .port_oe_o  (port_oe_o),
    .pwm_o      (pwm_o),
    .pwm_oe_o   (pwm_oe_o)
  );

  assign sys_rst_o    = sys_rst;
  assign cpu_clk_en_o = (mode == MODE_RUN);
  assign osc_en_o     = (mode != MODE_PD);
  assign pcon_o       = mode;

  // R7
  a_r7_clk_gating: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_clk_en_o && pcon_o != 2'b00) && (osc_en_o || pcon_o == 2'b10));
endmodule

// File: tb/lpm_pin_ctrl_tb.sv
module lpm_pin_ctrl_tb_top;
  localparam int STABLE_CYC = 8;
  localparam int PWM_N = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic osc_stable = 1'b0;
  logic pcon_we = 1'b0;
  logic [1:0] pcon_wdata = 2'b00;
  logic irq = 1'b0;
  logic ext_prog = 1'b0;
  logic ale = 1'b0, psen = 1'b1;
  logic [3:0][7:0] drv = {8'h11, 8'h22, 8'h33, 8'h44};
  logic [3:0][7:0] lat = {8'h3C, 8'hA5, 8'h5A, 8'hC3};
  logic [3:0] oe_n = 4'b1010;
  logic [PWM_N-1:0] pwm = 2'b11;

  logic sys_rst, cpu_en, osc_en, ale_o, psen_o;
  logic [1:0] pcon;
  logic [3:0][7:0] port_o;
  logic [3:0] port_oe;
  logic [PWM_N-1:0] pwm_o, pwm_oe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  lpm_pin_ctrl #(.STABLE_CYC(STABLE_CYC), .PWM_N(PWM_N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .osc_stable_i(osc_stable),
    .pcon_we_i(pcon_we), .pcon_wdata_i(pcon_wdata), .irq_i(irq),
    .ext_prog_i(ext_prog), .ale_i(ale), .psen_i(psen),
    .port_drv_i(drv), .port_lat_i(lat), .port_oe_i(oe_n), .pwm_i(pwm),
    .sys_rst_o(sys_rst), .cpu_clk_en_o(cpu_en), .osc_en_o(osc_en),
    .pcon_o(pcon), .ale_o(ale_o), .psen_o(psen_o), .port_o(port_o),
    .port_oe_o(port_oe), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] d);
    pcon_we = 1'b1; pcon_wdata = d;
    cyc(1);
    pcon_we = 1'b0; pcon_wdata = 2'b00;
  endtask

  task automatic boot();
    rst_ni = 1'b0; osc_stable = 1'b0;
    cyc(2);
    rst_ni = 1'b1; osc_stable = 1'b1;
    cyc(STABLE_CYC + 1);
  endtask

  task automatic chk_lowpower(input bit is_pd, input string tag);
    chk(ale_o == !is_pd && psen_o == !is_pd, {tag, " R9 strobes"}, {ale_o, psen_o}, {2{!is_pd}});
    if (ext_prog) chk(port_oe[0] == 1'b0 && port_o[0] == 8'h00, {tag, " R10 p0 float"}, {port_oe[0], port_o[0]}, 9'h000);
    else          chk(port_oe[0] && port_o[0] == lat[0], {tag, " R10 p0 latch"}, {port_oe[0], port_o[0]}, {1'b1, lat[0]});
    if (ext_prog && !is_pd) chk(port_o[2] == drv[2] && port_oe[2], {tag, " R11 p2 addr"}, port_o[2], drv[2]);
    else                    chk(port_o[2] == lat[2] && port_oe[2], {tag, " R11 p2 latch"}, port_o[2], lat[2]);
    chk(port_o[1] == lat[1] && port_o[3] == lat[3] && port_oe[1] && port_oe[3], {tag, " R12 p1 p3"},
        {port_o[3], port_o[1]}, {lat[3], lat[1]});
    chk(pwm_oe == '0 && pwm_o == '0, {tag, " R12 pwm"}, {pwm_oe, pwm_o}, 0);
    chk(cpu_en == 1'b0 && osc_en == !is_pd, {tag, " R7 clocks"}, {cpu_en, osc_en}, {1'b0, !is_pd});
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0; cyc(2);
    chk(sys_rst == 1'b1, "R1 sys_rst", sys_rst, 1);
    chk(pcon == 2'b00 && cpu_en && osc_en, "R1 mode/clocks", {pcon, cpu_en, osc_en}, 4'b0011);
    chk(port_o == drv && port_oe == oe_n && ale_o == ale && psen_o == psen, "R8 normal pins in reset",
        port_o, drv);
  endtask

  task automatic t_release();
    rst_ni = 1'b1; osc_stable = 1'b0;
    cyc(5);
    chk(sys_rst == 1'b1, "R2 held while unstable", sys_rst, 1);
    osc_stable = 1'b1; cyc(STABLE_CYC - 2);
    osc_stable = 1'b0; cyc(1);  // glitch restarts count
    osc_stable = 1'b1; cyc(STABLE_CYC - 1);
    chk(sys_rst == 1'b1, "R2 still held one short", sys_rst, 1);
    cyc(1);
    chk(sys_rst == 1'b0, "R2 released after count", sys_rst, 0);
    osc_stable = 1'b0; cyc(3);
    chk(sys_rst == 1'b0, "R3 sticky release", sys_rst, 0);
    osc_stable = 1'b1;
  endtask

  task automatic t_normal_pins();
    ale = 1'b1; psen = 1'b0; cyc(1);
    chk(ale_o && !psen_o && port_o == drv && port_oe == oe_n, "R8 normal pins", port_o, drv);
    chk(pwm_o == pwm && pwm_oe == '1, "R8 pwm normal", {pwm_oe, pwm_o}, {2'b11, pwm});
    irq = 1'b1; cyc(2); irq = 1'b0;
    chk(pcon == 2'b00 && cpu_en, "R5 irq ignored in normal", pcon, 0);
    wr(2'b00); cyc(1);
    chk(pcon == 2'b00, "R4 write 00 ignored", pcon, 0);
  endtask

  task automatic t_idle(input bit ext);
    ext_prog = ext;
    wr(2'b01);
    chk(pcon == 2'b01, "R4 enter idle", pcon, 2'b01);
    chk_lowpower(1'b0, ext ? "idle ext" : "idle int");
    wr(2'b10);
    chk(pcon == 2'b01, "R4 write ignored in idle", pcon, 2'b01);
    irq = 1'b1; cyc(1); irq = 1'b0;
    chk(pcon == 2'b00 && cpu_en, "R5 idle wake", pcon, 0);
  endtask

  task automatic t_pd(input bit ext, input logic [1:0] wd);
    ext_prog = ext;
    wr(wd);
    chk(pcon == 2'b10, "R4 enter power-down", pcon, 2'b10);
    chk_lowpower(1'b1, ext ? "pd ext" : "pd int");
    irq = 1'b1; cyc(3); irq = 1'b0;
    wr(2'b01);
    chk(pcon == 2'b10, "R6 pd ignores irq and writes", pcon, 2'b10);
    #1 rst_ni = 1'b0; #1;
    chk(pcon == 2'b00 && sys_rst, "R6 reset exits pd", {pcon, sys_rst}, 3'b001);
    cyc(1);
    rst_ni = 1'b1; osc_stable = 1'b1;
    cyc(STABLE_CYC);
    chk(sys_rst == 1'b0 && pcon == 2'b00 && osc_en, "R6 back to normal", {sys_rst, pcon}, 0);
  endtask

  initial begin : watchdog
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(1);
    t_reset_state();
    t_release();
    t_normal_pins();
    t_idle(1'b0);
    t_idle(1'b1);
    t_pd(1'b0, 2'b10);
    t_pd(1'b1, 2'b11);  // both bits: power-down priority
    boot();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule